// File: doc/BRIEF.md
# Two-Issue Cascaded Integer ALU

This block is a two-stage integer execution unit that accepts up to two operations in the same clock cycle. Each operation carries a 3-bit opcode, two operand values and a destination register tag. The second slot also carries the register numbers of its two sources. The unit holds three ALUs. Two first-stage ALUs serve the two issue slots. A third, cascade ALU sits in the second stage.

When the two operations are unrelated, both are computed side by side in stage 1, and the stage-2 register only carries them forward. When the second operation reads the register that the first one writes, the first operation is computed in stage 1. The second is then computed in stage 2 on the cascade ALU, and the stage-1 result takes the place of the matching operand. A dependent pair therefore issues in a single cycle without a stall. Both slots always deliver results, with their tags and valid bits, two accepted clock edges after issue.

A stall input freezes both pipeline registers. The block has no register file and no forwarding from other units, so the operand values come from outside.

Top module: `dual_cascade_alu`

## Requirements
- R1: An operation presented with `stall` low is captured at the next rising edge, and its result appears on the output of its own slot after the following rising edge on which `stall` is also low. The latency is the same whether the pair is independent or dependent.
- R2: Opcodes give these results: 0 is a+b, 1 is a-b, 2 is a AND b, 3 is a OR b, 4 is a XOR b, 5 is a shifted left by b, 6 is a shifted right logically by b, and 7 passes b. All arithmetic wraps modulo 2^DATA_W.
- R3: When no dependence exists, slot 1 is computed from its own `in1_a` and `in1_b`, and slot 0 is always computed from `in0_a` and `in0_b`.
- R4: A dependence exists when both slots are valid and `in0_dst` equals `in1_src_a`, `in1_src_b` or both. Every matching operand of slot 1 is then replaced by the slot 0 result.
- R5: An invalid slot never produces a valid result. A slot 0 operation issued alone works. When either slot is invalid, no operand substitution takes place, even if the register numbers match.
- R6: Each valid result carries the destination tag that was issued with its operation, on the output of the same slot.
- R7: While `stall` is high, all outputs hold their values and the inputs are ignored. No operation is lost or duplicated across a stall.
- R8: After a synchronous active-low reset, both output valid bits are low.
- R9: Shift amounts use only the low log2(DATA_W) bits of b. The higher bits of b have no effect on a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freezes both pipeline registers |
| in0_valid | input | 1 | Slot 0 carries an operation |
| in0_op | input | 3 | Slot 0 opcode |
| in0_a | input | DATA_W | Slot 0 first operand |
| in0_b | input | DATA_W | Slot 0 second operand |
| in0_dst | input | REG_W | Slot 0 destination register |
| in1_valid | input | 1 | Slot 1 carries an operation |
| in1_op | input | 3 | Slot 1 opcode |
| in1_a | input | DATA_W | Slot 1 first operand |
| in1_b | input | DATA_W | Slot 1 second operand |
| in1_src_a | input | REG_W | Register number that supplied in1_a |
| in1_src_b | input | REG_W | Register number that supplied in1_b |
| in1_dst | input | REG_W | Slot 1 destination register |
| out0_valid | output | 1 | Slot 0 result valid |
| out0_dst | output | REG_W | Slot 0 result tag |
| out0_data | output | DATA_W | Slot 0 result |
| out1_valid | output | 1 | Slot 1 result valid |
| out1_dst | output | REG_W | Slot 1 result tag |
| out1_data | output | DATA_W | Slot 1 result |

## Verification
The bench sweeps every pair of opcodes across six specifier patterns: independent, a match on the first source, a match on the second source, a match on both, slot 1 alone valid, and slot 0 alone valid. A design that ignored one of the two comparators, or that substituted an operand when a slot was invalid, would return slot 1 results built from the wrong operand. A design that did not honour `stall` would drop or repeat a pair around the stall cycles, which the bench inserts every seventh cycle. Random operands with high bits set in b expose a shifter that reads too many bits of the shift amount, and back-to-back issue exposes a cascade path that arrives one cycle early or late.

// File: rtl/dual_alu_pkg.sv
// Shared opcode encoding for the two-issue cascaded ALU.
package dual_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_t;
endpackage

// File: rtl/cascade_alu_core.sv
// Combinational integer ALU used for both first-stage slots and the cascade stage.
// Assumes: W is a power of two; shifts take the low log2(W) bits of b.
module cascade_alu_core
    import dual_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    // Select the result of the requested operation.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << shamt;
            OP_SHR:  y = a >> shamt;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/pair_dep_detect.sv
// Detects that the slot 1 operation reads the register written by slot 0.
// Assumes: both slots must be valid for a dependence to exist.
module pair_dep_detect #(
    parameter int RW = 5
) (
    input  logic          v0,
    input  logic          v1,
    input  logic [RW-1:0] dst0,
    input  logic [RW-1:0] src1_a,
    input  logic [RW-1:0] src1_b,
    output logic          fwd_a,
    output logic          fwd_b
);
    logic both_valid;

    // Compare each slot 1 source with the slot 0 destination.
    always_comb begin
        both_valid = v0 && v1;
        fwd_a      = both_valid && (dst0 == src1_a);
        fwd_b      = both_valid && (dst0 == src1_b);
    end
endmodule

// File: rtl/dual_cascade_alu.sv
// Two-issue, two-stage integer unit. Stage 1 holds one ALU per slot. Stage 2
// holds a cascade ALU that finishes a slot 1 operation depending on slot 0.
// Assumes: operands are supplied from outside; stall freezes both stages and
// the inputs are not taken while stall is high.
module dual_cascade_alu
    import dual_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              in0_valid,
    input  logic [2:0]        in0_op,
    input  logic [DATA_W-1:0] in0_a,
    input  logic [DATA_W-1:0] in0_b,
    input  logic [REG_W-1:0]  in0_dst,
    input  logic              in1_valid,
    input  logic [2:0]        in1_op,
    input  logic [DATA_W-1:0] in1_a,
    input  logic [DATA_W-1:0] in1_b,
    input  logic [REG_W-1:0]  in1_src_a,
    input  logic [REG_W-1:0]  in1_src_b,
    input  logic [REG_W-1:0]  in1_dst,
    output logic              out0_valid,
    output logic [REG_W-1:0]  out0_dst,
    output logic [DATA_W-1:0] out0_data,
    output logic              out1_valid,
    output logic [REG_W-1:0]  out1_dst,
    output logic [DATA_W-1:0] out1_data
);
    localparam int SLOTS = 2;

    // Slot-indexed views of the inputs.
    alu_op_t           op_in [SLOTS];
    logic [DATA_W-1:0] a_in  [SLOTS];
    logic [DATA_W-1:0] b_in  [SLOTS];
    logic [DATA_W-1:0] s1_y  [SLOTS];

    // Gather the two issue slots into arrays.
    always_comb begin
        op_in[0] = alu_op_t'(in0_op);
        op_in[1] = alu_op_t'(in1_op);
        a_in[0]  = in0_a;
        a_in[1]  = in1_a;
        b_in[0]  = in0_b;
        b_in[1]  = in1_b;
    end

    // First-stage ALUs, one for each slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_stage1_alu
        cascade_alu_core #(.W(DATA_W)) u_alu (
            .op (op_in[s]),
            .a  (a_in[s]),
            .b  (b_in[s]),
            .y  (s1_y[s])
        );
    end

    logic dep_a, dep_b;
    pair_dep_detect #(.RW(REG_W)) u_dep (
        .v0     (in0_valid),
        .v1     (in1_valid),
        .dst0   (in0_dst),
        .src1_a (in1_src_a),
        .src1_b (in1_src_b),
        .fwd_a  (dep_a),
        .fwd_b  (dep_b)
    );

    // Stage 1 pipeline register.
    logic              s1_v0, s1_v1, s1_fa, s1_fb;
    logic [REG_W-1:0]  s1_d0, s1_d1;
    logic [DATA_W-1:0] s1_r0, s1_r1, s1_a1, s1_b1;
    alu_op_t           s1_op1;

    // Capture the stage-1 results and the slot 1 operands when not stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v0  <= 1'b0;
            s1_v1  <= 1'b0;
            s1_fa  <= 1'b0;
            s1_fb  <= 1'b0;
            s1_d0  <= '0;
            s1_d1  <= '0;
            s1_r0  <= '0;
            s1_r1  <= '0;
            s1_a1  <= '0;
            s1_b1  <= '0;
            s1_op1 <= OP_ADD;
        end else if (!stall) begin
            s1_v0  <= in0_valid;
            s1_v1  <= in1_valid;
            s1_fa  <= dep_a;
            s1_fb  <= dep_b;
            s1_d0  <= in0_dst;
            s1_d1  <= in1_dst;
            s1_r0  <= s1_y[0];
            s1_r1  <= s1_y[1];
            s1_a1  <= in1_a;
            s1_b1  <= in1_b;
            s1_op1 <= op_in[1];
        end
    end

    // Cascade ALU: finishes the dependent slot 1 operation using the slot 0 result.
    logic [DATA_W-1:0] cas_a, cas_b, cas_y, slot1_final;
    always_comb begin
        cas_a = s1_fa ? s1_r0 : s1_a1;
        cas_b = s1_fb ? s1_r0 : s1_b1;
    end

    cascade_alu_core #(.W(DATA_W)) u_cascade (
        .op (s1_op1),
        .a  (cas_a),
        .b  (cas_b),
        .y  (cas_y)
    );

    // Choose the cascade result for a dependent pair, else the stage-1 result.
    assign slot1_final = (s1_fa || s1_fb) ? cas_y : s1_r1;

    // Stage 2 output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out0_valid <= 1'b0;
            out1_valid <= 1'b0;
            out0_dst   <= '0;
            out1_dst   <= '0;
            out0_data  <= '0;
            out1_data  <= '0;
        end else if (!stall) begin
            out0_valid <= s1_v0;
            out1_valid <= s1_v1;
            out0_dst   <= s1_d0;
            out1_dst   <= s1_d1;
            out0_data  <= s1_r0;
            out1_data  <= slot1_final;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable({out0_valid, out1_valid, out0_dst, out1_dst, out0_data, out1_data}));

    // R5
    idle_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !in0_valid) |=> !s1_v0);

    // R5
    idle_out1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !s1_v1) |=> !out1_valid);

    // R4
    cascade_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_fa || s1_fb) |-> (s1_v0 && s1_v1));

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && s1_v0) |=> (out0_valid && out0_data == $past(s1_r0)));
endmodule

// File: tb/dual_cascade_alu_tb.sv
module dual_cascade_alu_tb;
    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam int RW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          in0_valid = 1'b0, in1_valid = 1'b0;
    logic [2:0]    in0_op = '0, in1_op = '0;
    logic [W-1:0]  in0_a = '0, in0_b = '0, in1_a = '0, in1_b = '0;
    logic [RW-1:0] in0_dst = '0, in1_src_a = '0, in1_src_b = '0, in1_dst = '0;
    logic          out0_valid, out1_valid;
    logic [RW-1:0] out0_dst, out1_dst;
    logic [W-1:0]  out0_data, out1_data;

    always #(CLK_P/2) clk = ~clk;

    dual_cascade_alu #(.DATA_W(W), .REG_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .in0_valid(in0_valid), .in0_op(in0_op), .in0_a(in0_a), .in0_b(in0_b), .in0_dst(in0_dst),
        .in1_valid(in1_valid), .in1_op(in1_op), .in1_a(in1_a), .in1_b(in1_b),
        .in1_src_a(in1_src_a), .in1_src_b(in1_src_b), .in1_dst(in1_dst),
        .out0_valid(out0_valid), .out0_dst(out0_dst), .out0_data(out0_data),
        .out1_valid(out1_valid), .out1_dst(out1_dst), .out1_data(out1_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] lcg = 32'h1234_5678;

    // Bench model of the two pipeline stages.
    logic          m1_v[2], m2_v[2];
    logic [RW-1:0] m1_t[2], m2_t[2];
    logic [W-1:0]  m1_x[2], m2_x[2];
    string         m1_g[2], m2_g[2];

    function automatic logic [W-1:0] ref_alu(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        int sh;
        sh = int'(b % W); // R9: only low log2(W) bits matter
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << sh;
            3'd6: return a >> sh;
            default: return b;
        endcase
    endfunction

    function automatic logic [W-1:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:16];
    endfunction

    task automatic check_slot(input int s, input logic v, input logic [RW-1:0] t, input logic [W-1:0] x);
        n_vec++;
        if (v !== m2_v[s]) begin
            n_bad++;
            $display("FAIL %s slot%0d valid: got %0b exp %0b", m2_g[s], s, v, m2_v[s]);
        end else if (v) begin
            if (t !== m2_t[s]) begin
                n_bad++;
                $display("FAIL R6 slot%0d tag: got %0d exp %0d", s, t, m2_t[s]);
            end
            if (x !== m2_x[s]) begin
                n_bad++;
                $display("FAIL %s (R1 timing) slot%0d data: got %h exp %h", m2_g[s], s, x, m2_x[s]);
            end
        end
    endtask

    task automatic check_out();
        check_slot(0, out0_valid, out0_dst, out0_data);
        check_slot(1, out1_valid, out1_dst, out1_data);
    endtask

    // One clock: check outputs, drive the next inputs, advance the model.
    task automatic step(input logic st,
                        input logic v0, input logic [2:0] op0, input logic [W-1:0] a0, input logic [W-1:0] b0, input logic [RW-1:0] d0,
                        input logic v1, input logic [2:0] op1, input logic [W-1:0] a1, input logic [W-1:0] b1,
                        input logic [RW-1:0] sa, input logic [RW-1:0] sb, input logic [RW-1:0] d1, input string g1);
        logic [W-1:0] r0, ea, eb;
        logic fa, fb;
        @(negedge clk);
        check_out();
        cyc++;
        stall = st;
        in0_valid = v0; in0_op = op0; in0_a = a0; in0_b = b0; in0_dst = d0;
        in1_valid = v1; in1_op = op1; in1_a = a1; in1_b = b1;
        in1_src_a = sa; in1_src_b = sb; in1_dst = d1;
        if (st) begin
            // R7: outputs must hold for the next check
            m2_g[0] = "R7";
            m2_g[1] = "R7";
        end else begin
            for (int s = 0; s < 2; s++) begin
                m2_v[s] = m1_v[s]; m2_t[s] = m1_t[s]; m2_x[s] = m1_x[s]; m2_g[s] = m1_g[s];
            end
            r0 = ref_alu(op0, a0, b0);
            fa = v0 && v1 && (d0 == sa); // R4
            fb = v0 && v1 && (d0 == sb);
            ea = fa ? r0 : a1;
            eb = fb ? r0 : b1;
            m1_v[0] = v0; m1_t[0] = d0; m1_x[0] = r0;
            m1_g[0] = (op0 == 3'd5 || op0 == 3'd6) ? "R9" : "R2";
            m1_v[1] = v1; m1_t[1] = d1; m1_x[1] = ref_alu(op1, ea, eb);
            m1_g[1] = g1;
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 3'd0, '0, '0, '0, 1'b0, 3'd0, '0, '0, '0, '0, '0, "R5");
    endtask

    bit done = 0;

    initial begin
        for (int s = 0; s < 2; s++) begin
            m1_v[s] = 0; m2_v[s] = 0; m1_t[s] = '0; m2_t[s] = '0;
            m1_x[s] = '0; m2_x[s] = '0; m1_g[s] = "R8"; m2_g[s] = "R8";
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: outputs idle right after reset
        @(negedge clk);
        n_vec++;
        if (out0_valid !== 1'b0 || out1_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 reset valids: got %0b%0b exp 00", out0_valid, out1_valid);
        end
        for (int op0 = 0; op0 < 8; op0++) begin
            for (int op1 = 0; op1 < 8; op1++) begin
                for (int mode = 0; mode < 6; mode++) begin
                    logic [RW-1:0] d, sa, sb;
                    logic v0, v1;
                    string g;
                    d = RW'(op0 + op1 + mode);
                    sa = d + RW'(1);
                    sb = d + RW'(2);
                    v0 = 1'b1; v1 = 1'b1; g = "R3";
                    case (mode)
                        1: begin sa = d; g = "R4"; end
                        2: begin sb = d; g = "R4"; end
                        3: begin sa = d; sb = d; g = "R4"; end
                        4: begin sa = d; sb = d; v1 = 1'b0; g = "R5"; end
                        5: begin sa = d; v0 = 1'b0; g = "R5"; end
                        default: ;
                    endcase
                    if (cyc % 7 == 3) begin
                        // R7: junk vector during stall must be ignored
                        step(1'b1, 1'b1, 3'(op1), rnd(), rnd(), d + RW'(5),
                             1'b1, 3'(op0), rnd(), rnd(), d + RW'(5), d, d + RW'(6), "R7");
                    end
                    step(1'b0, v0, 3'(op0), rnd(), rnd(), d,
                         v1, 3'(op1), rnd(), rnd(), sa, sb, d + RW'(3), g);
                end
            end
        end
        // R5: slot 0 alone, then drain
        step(1'b0, 1'b1, 3'd0, 16'h00ff, 16'h0001, 3'd2, 1'b0, 3'd0, '0, '0, 3'd2, 3'd2, 3'd2, "R5");
        idle();
        idle();
        idle();
        @(negedge clk);
        check_out();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule